// File: doc/BRIEF.md
# Branch-and-Link Execute Unit with Flag Save

This unit executes the single jump-and-link operation of a small processor that has a 512-word register file and two condition flags, zero (Z) and carry (C). A plain jump, a subroutine call and a subroutine return are all coded as this one operation, and only the operands differ. The unit receives the decoded destination address, the branch target from the source field, the current program counter, the current flags, the current contents of the destination register, and two enables that let the operation overwrite Z and C. One cycle later it presents the next program counter, the new flag values and a register write-back word.

The write-back word is a link word. Its low nine bits hold the return address, which is the current PC plus one, wrapping at 512. Bit 9 holds C and bit 10 holds Z, both as they were before the operation. Bits 31..11 keep the old contents of the destination register. For an ordinary destination, enabled flags load from bits 10 (Z) and 9 (C) of the old register contents. A return therefore names the register that a call linked into, branches to the address stored in it, and enables both flag writes to restore the saved flags. The four pin-port addresses 0x1F8..0x1FB are treated differently. No write-back is issued for them, and enabled flags load from the destination address field itself: bit 1 gives Z and bit 0 gives C. A plain jump names the scratch address 0x1F4 and enables no flag write.

A three-state result machine controls the outputs:
- ST_IDLE: no result is presented.
- ST_LINK: a result with a register write-back is presented.
- ST_PORT: a result with a pin-port destination and no write is presented.

Every state moves on each clock, and the transitions do not depend on the current state:
- A cycle without `op_valid` moves to ST_IDLE.
- `op_valid` with a pin-port destination moves to ST_PORT.
- `op_valid` with any other destination moves to ST_LINK.

Top module: `link_branch_unit`

## Requirements
- R1: While reset is active and after it is released with no operation, `res_valid`, `wb_en`, `pc_next`, `z_next`, `c_next`, `wb_addr` and `wb_data` are all 0.
- R2: `res_valid` is 1 in exactly the cycles that follow a cycle with `op_valid` high, and `pc_next` then equals the `src_target` of that operation.
- R3: For an ordinary destination, `wb_data[8:0]` equals `pc_cur + 1` modulo 512, so PC 511 links as 0.
- R4: For an ordinary destination, `wb_en` is 1, `wb_addr` equals `dst_addr`, `wb_data[10]` equals the pre-operation `z_cur`, `wb_data[9]` equals the pre-operation `c_cur`, and `wb_data[31:11]` equals `dst_rdata[31:11]`.
- R5: For an ordinary destination, `z_next` equals `dst_rdata[10]` when `wr_z` is 1, and `c_next` equals `dst_rdata[9]` when `wr_c` is 1. The old contents are used, not the link word being written.
- R6: A flag whose write enable is 0 takes the value of `z_cur` or `c_cur` presented with the operation.
- R7: For `dst_addr` 0x1F8..0x1FB, `wb_en` is 0. With the matching enable set, `z_next` equals `dst_addr[1]` and `c_next` equals `dst_addr[0]`.
- R8: In a cycle that follows no operation, `res_valid` and `wb_en` are 0, and `pc_next`, `z_next`, `c_next` and `wb_data` keep the values of the last result.
- R9: A jump with `dst_addr` 0x1F4 and both enables at 0 branches to `src_target` and leaves both flags at their previous values.
- R10: A call that links into a register, followed by a return that names the same register, takes its target from bits 8..0 of that register and sets both enables. This restores the PC to the call's PC plus one and restores the flags that were current at the call.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| dst_addr | input | 9 | Destination register address |
| src_target | input | 9 | Branch target |
| pc_cur | input | 9 | PC of the issuing instruction |
| z_cur | input | 1 | Current Z flag |
| c_cur | input | 1 | Current C flag |
| dst_rdata | input | 32 | Old contents of the destination register |
| wr_z | input | 1 | Allow Z to be updated |
| wr_c | input | 1 | Allow C to be updated |
| res_valid | output | 1 | Result presented this cycle |
| wb_en | output | 1 | Register write-back request |
| wb_addr | output | 9 | Write-back address |
| wb_data | output | 32 | Link word to write |
| pc_next | output | 9 | Next PC |
| z_next | output | 1 | Updated Z flag |
| c_next | output | 1 | Updated C flag |

## Verification
The hardest case to reach is a return. It only means something when the destination register already holds a link word written by an earlier call, and when the flags have been changed in between. The bench therefore keeps its own copy of the register file, which every write-back updates. It drives a directed call, a flag-changing operation and a return through that copy, and it feeds the copy's contents back as `dst_rdata`. The pin-port window and PC 511 are too narrow to be hit often by chance, so they are driven directly. Random operations are then weighted toward the pin-port addresses.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LINK = 2'd1,
        ST_PORT = 2'd2
    } lbu_state_e;

    typedef struct packed {
        logic z;
        logic c;
    } flag_pair_t;

endpackage

// File: rtl/lbu_port_detect.sv
module lbu_port_detect #(
    parameter int ADDR_W     = 9,
    parameter int PORT_BASE  = 'h1F8,
    parameter int PORT_COUNT = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [PORT_COUNT-1:0] match;

    for (genvar gi = 0; gi < PORT_COUNT; gi++) begin : g_port
        localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(PORT_BASE + gi);
        assign match[gi] = (addr == PORT_ADDR);
    end

    assign hit = |match;
endmodule

// File: rtl/lbu_flag_sel.sv
module lbu_flag_sel
    import lbu_pkg::*;
(
    input  logic       is_port,
    input  logic [1:0] addr_lsb,
    input  flag_pair_t reg_flags,
    input  flag_pair_t cur_flags,
    input  logic       wr_z,
    input  logic       wr_c,
    output flag_pair_t new_flags
);
    flag_pair_t src_flags;

    always_comb begin
        if (is_port) begin
            src_flags.z = addr_lsb[1];
            src_flags.c = addr_lsb[0];
        end else begin
            src_flags = reg_flags;
        end
        new_flags.z = wr_z ? src_flags.z : cur_flags.z;
        new_flags.c = wr_c ? src_flags.c : cur_flags.c;
    end
endmodule

// File: rtl/lbu_link_pack.sv
module lbu_link_pack
    import lbu_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] pc_cur,
    input  flag_pair_t        cur_flags,
    input  logic [DATA_W-1:0] old_word,
    output logic [DATA_W-1:0] link_word
);
    localparam int C_BIT = ADDR_W;
    localparam int Z_BIT = ADDR_W + 1;

    always_comb begin
        link_word               = old_word;
        link_word[ADDR_W-1:0]   = pc_cur + ADDR_W'(1);
        link_word[C_BIT]        = cur_flags.c;
        link_word[Z_BIT]        = cur_flags.z;
    end
endmodule

// File: rtl/link_branch_unit.sv
module link_branch_unit
    import lbu_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 32,
    parameter int PORT_BASE  = 'h1F8,
    parameter int PORT_COUNT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [ADDR_W-1:0] src_target,
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic              z_cur,
    input  logic              c_cur,
    input  logic [DATA_W-1:0] dst_rdata,
    input  logic              wr_z,
    input  logic              wr_c,
    output logic              res_valid,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic [ADDR_W-1:0] pc_next,
    output logic              z_next,
    output logic              c_next
);
    localparam int C_BIT = ADDR_W;
    localparam int Z_BIT = ADDR_W + 1;

    lbu_state_e        state_q, state_d;
    logic              port_hit;
    flag_pair_t        cur_flags, reg_flags, upd_flags;
    logic [DATA_W-1:0] link_word;
    logic [ADDR_W-1:0] pc_q, addr_q;
    logic [DATA_W-1:0] data_q;
    flag_pair_t        flags_q;

    assign cur_flags.z = z_cur;
    assign cur_flags.c = c_cur;
    assign reg_flags.z = dst_rdata[Z_BIT];
    assign reg_flags.c = dst_rdata[C_BIT];

    lbu_port_detect #(
        .ADDR_W    (ADDR_W),
        .PORT_BASE (PORT_BASE),
        .PORT_COUNT(PORT_COUNT)
    ) i_port (
        .addr(dst_addr),
        .hit (port_hit)
    );

    lbu_flag_sel i_flags (
        .is_port  (port_hit),
        .addr_lsb (dst_addr[1:0]),
        .reg_flags(reg_flags),
        .cur_flags(cur_flags),
        .wr_z     (wr_z),
        .wr_c     (wr_c),
        .new_flags(upd_flags)
    );

    lbu_link_pack #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) i_link (
        .pc_cur   (pc_cur),
        .cur_flags(cur_flags),
        .old_word (dst_rdata),
        .link_word(link_word)
    );

    // next-state selection
    always_comb begin
        if (!op_valid)     state_d = ST_IDLE;
        else if (port_hit) state_d = ST_PORT;
        else               state_d = ST_LINK;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result datapath, loaded only when an operation issues
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            flags_q <= '0;
        end else if (op_valid) begin
            pc_q    <= src_target;
            addr_q  <= dst_addr;
            data_q  <= link_word;
            flags_q <= upd_flags;
        end
    end

    // outputs decoded from state
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin res_valid = 1'b0; wb_en = 1'b0; end
            ST_LINK: begin res_valid = 1'b1; wb_en = 1'b1; end
            ST_PORT: begin res_valid = 1'b1; wb_en = 1'b0; end
            default: begin res_valid = 1'b0; wb_en = 1'b0; end
        endcase
    end

    assign wb_addr = addr_q;
    assign wb_data = data_q;
    assign pc_next = pc_q;
    assign z_next  = flags_q.z;
    assign c_next  = flags_q.c;
endmodule

// File: rtl/lbu_checker.sv
module lbu_checker #(
    parameter int ADDR_W     = 9,
    parameter int PORT_BASE  = 'h1F8,
    parameter int PORT_COUNT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [ADDR_W-1:0] src_target,
    input logic [ADDR_W-1:0] pc_cur,
    input logic              z_cur,
    input logic              c_cur,
    input logic              rd_z,
    input logic              wr_z,
    input logic              res_valid,
    input logic              wb_en,
    input logic [ADDR_W+1:0] wb_low,
    input logic [ADDR_W-1:0] pc_next,
    input logic              z_next
);
    logic in_port;
    assign in_port = (int'(dst_addr) >= PORT_BASE) &&
                     (int'(dst_addr) < PORT_BASE + PORT_COUNT);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !wb_en));
    a_r2_target: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> pc_next == $past(src_target));
    a_r3_link_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !in_port) |=> wb_low[ADDR_W-1:0] == ADDR_W'($past(pc_cur) + 1'b1));
    a_r4_link_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !in_port) |=> (wb_en && wb_low[ADDR_W+1] == $past(z_cur)
                                    && wb_low[ADDR_W] == $past(c_cur)));
    a_r5_z_from_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !in_port && wr_z) |=> z_next == $past(rd_z));
    a_r6_z_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_z) |=> z_next == $past(z_cur));
    a_r7_port_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && in_port) |=> !wb_en);
endmodule

bind link_branch_unit lbu_checker #(
    .ADDR_W    (ADDR_W),
    .PORT_BASE (PORT_BASE),
    .PORT_COUNT(PORT_COUNT)
) i_lbu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .dst_addr  (dst_addr),
    .src_target(src_target),
    .pc_cur    (pc_cur),
    .z_cur     (z_cur),
    .c_cur     (c_cur),
    .rd_z      (dst_rdata[ADDR_W+1]),
    .wr_z      (wr_z),
    .res_valid (res_valid),
    .wb_en     (wb_en),
    .wb_low    (wb_data[ADDR_W+1:0]),
    .pc_next   (pc_next),
    .z_next    (z_next)
);

// File: tb/test_link_branch_unit.sv
module test_link_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [8:0]  dst_addr = '0, src_target = '0, pc_cur = '0;
    logic        z_cur = 1'b0, c_cur = 1'b0, wr_z = 1'b0, wr_c = 1'b0;
    logic [31:0] dst_rdata = '0;
    logic        res_valid, wb_en, z_next, c_next;
    logic [8:0]  wb_addr, pc_next;
    logic [31:0] wb_data;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] regs [512];
    logic [8:0]  arch_pc = 9'h020;
    logic        arch_z = 1'b1, arch_c = 1'b0;

    always #5 clk = ~clk;

    link_branch_unit i_link_branch_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .dst_addr(dst_addr),
        .src_target(src_target), .pc_cur(pc_cur), .z_cur(z_cur), .c_cur(c_cur),
        .dst_rdata(dst_rdata), .wr_z(wr_z), .wr_c(wr_c), .res_valid(res_valid),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data), .pc_next(pc_next),
        .z_next(z_next), .c_next(c_next)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic is_port(logic [8:0] a);
        return (a >= 9'h1F8) && (a <= 9'h1FB);
    endfunction

    function automatic logic [31:0] exp_link(logic [31:0] old, logic [8:0] pc, logic z, logic c);
        return {old[31:11], z, c, 9'(pc + 9'd1)};
    endfunction

    // Issue one operation from the architectural state and check its result.
    task automatic run_op(logic [8:0] dst, logic [8:0] tgt, logic wz, logic wc);
        logic [31:0] old;
        logic        ez, ec, port;
        old  = regs[dst];
        port = is_port(dst);
        ez   = wz ? (port ? dst[1] : old[10]) : arch_z;
        ec   = wc ? (port ? dst[0] : old[9])  : arch_c;
        @(negedge clk);
        op_valid = 1'b1; dst_addr = dst; src_target = tgt; pc_cur = arch_pc;
        z_cur = arch_z; c_cur = arch_c; dst_rdata = old; wr_z = wz; wr_c = wc;
        @(negedge clk);
        op_valid = 1'b0;
        check("R2 res_valid", 32'(res_valid), 32'd1);
        check("R2 pc_next", 32'(pc_next), 32'(tgt));
        if (port) begin
            check("R7 wb_en", 32'(wb_en), 32'd0);
            check("R7 z_next", 32'(z_next), 32'(ez));
            check("R7 c_next", 32'(c_next), 32'(ec));
        end else begin
            check("R4 wb_en", 32'(wb_en), 32'd1);
            check("R4 wb_addr", 32'(wb_addr), 32'(dst));
            check("R3 R4 wb_data", wb_data, exp_link(old, arch_pc, arch_z, arch_c));
            check("R5 R6 z_next", 32'(z_next), 32'(ez));
            check("R5 R6 c_next", 32'(c_next), 32'(ec));
            regs[dst] = exp_link(old, arch_pc, arch_z, arch_c);
        end
        arch_pc = tgt; arch_z = ez; arch_c = ec;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 512; i++) regs[i] = $urandom;
        repeat (3) @(negedge clk);
        check("R1 res_valid in reset", 32'(res_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 res_valid", 32'(res_valid), 32'd0);
        check("R1 wb_en", 32'(wb_en), 32'd0);
        check("R1 pc_next", 32'(pc_next), 32'd0);
        check("R1 flags", 32'({z_next, c_next}), 32'd0);
        check("R1 wb_data", wb_data, 32'd0);
        check("R1 wb_addr", 32'(wb_addr), 32'd0);

        // R10: call, disturb flags, return
        run_op(9'h0A0, 9'h100, 1'b0, 1'b0);
        regs[9'h0B0] = 32'h0000_0200;   // bit 9 set, bit 10 clear
        run_op(9'h0B0, 9'h140, 1'b1, 1'b1);
        check("R10 flags changed", 32'({arch_z, arch_c}), 32'b01);
        run_op(9'h0A0, regs[9'h0A0][8:0], 1'b1, 1'b1);
        check("R10 return pc", 32'(pc_next), 32'h021);
        check("R10 return z", 32'(z_next), 32'd1);
        check("R10 return c", 32'(c_next), 32'd0);

        // R9: plain jump through scratch address
        run_op(9'h1F4, 9'h055, 1'b0, 1'b0);
        check("R9 jump z", 32'(z_next), 32'd1);
        check("R9 jump c", 32'(c_next), 32'd0);

        // R7: pin-port destinations
        run_op(9'h1F9, 9'h060, 1'b1, 1'b1);
        run_op(9'h1FA, 9'h061, 1'b1, 1'b0);
        run_op(9'h1FB, 9'h062, 1'b0, 1'b1);
        run_op(9'h1F8, 9'h063, 1'b1, 1'b1);

        // R3: PC wrap
        arch_pc = 9'h1FF;
        run_op(9'h010, 9'h070, 1'b0, 1'b0);
        check("R3 wrap", 32'(regs[9'h010][8:0]), 32'd0);

        // R8: idle cycle holds results
        begin
            logic [8:0]  hp;
            logic [31:0] hd;
            logic        hz, hc;
            hp = pc_next; hd = wb_data; hz = z_next; hc = c_next;
            @(negedge clk);
            check("R8 res_valid", 32'(res_valid), 32'd0);
            check("R8 wb_en", 32'(wb_en), 32'd0);
            check("R8 pc_next", 32'(pc_next), 32'(hp));
            check("R8 wb_data", wb_data, hd);
            check("R8 flags", 32'({z_next, c_next}), 32'({hz, hc}));
        end

        // random operations, biased toward the pin-port window
        for (int i = 0; i < 400; i++) begin
            logic [8:0] d;
            d = ($urandom % 4 == 0) ? 9'(9'h1F6 + $urandom % 8) : 9'($urandom);
            run_op(d, 9'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom % 5 == 0) begin
                @(negedge clk);
                check("R8 idle res_valid", 32'(res_valid), 32'd0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule